// File: doc/BRIEF.md
# Dual-Core Watchdog Reset Router

This block sits between two window watchdogs and the reset and interrupt fabric of a two-core system. Each watchdog belongs to one core. When a watchdog reports a timeout with a one-cycle pulse, the router decides what gets reset. A sticky scope bit per watchdog makes that choice. Software can raise the bit once, and after that a timeout takes the whole system down instead of only the owning core. Every timeout also resets the watchdog that fired. It also latches an interrupt toward the other core, so each core learns that its partner has failed.

The router also turns each core's low-power state into watchdog control signals. A core in stop freezes its watchdog. A core domain in standby holds its watchdog in reset. A per-watchdog run bit models the clock enable. Writing 1 starts the watchdog. Writing 0 cannot stop a watchdog that is already running.

Software reaches the router through a simple write port with three registers, selected by address. Address 0 holds the scope bits. Address 1 holds the run bits. Address 2 is the interrupt-clear register. Bit i of the write data always refers to watchdog i or core i.

Top module: `wdr_router`

## Requirements
- R1: After reset, every output is low and both scope bits are 0.
- R2: A timeout on watchdog i while its scope bit is 0 drives coreRst[i] high for exactly 4 cycles, starting the cycle after the pulse. sysRst stays low, and the other core's reset is not touched.
- R3: A timeout on watchdog i while its scope bit is 1 drives sysRst high for exactly 4 cycles, starting the cycle after the pulse. No coreRst bit is raised.
- R4: A write to address 0 with data bit i set to 1 sets scope bit i. A data bit of 0 leaves the scope bit unchanged, so a set bit cannot be cleared by software.
- R5: A timeout that raises sysRst clears both scope bits. This clearing takes priority over a scope write in the same cycle.
- R6: Every timeout of watchdog i drives wdRst[i] high for exactly 4 cycles, starting the cycle after the pulse, whatever the scope.
- R7: A timeout of watchdog 0 sets crossIrq[1], and a timeout of watchdog 1 sets crossIrq[0]. The interrupt stays high until a write of 1 to bit j at address 2 clears crossIrq[j]. If a new timeout and a clear arrive in the same cycle, the interrupt stays set.
- R8: wdFreeze[i] follows coreStop[i] one cycle later.
- R9: wdClear[i] follows coreStandby[i] one cycle later. Standby on core i also clears wdRun[i].
- R10: A write of 1 to bit i at address 1 sets wdRun[i] on the next cycle. A write of 0 leaves it unchanged. A timeout of watchdog i clears wdRun[i].
- R11: When both watchdogs time out in the same cycle, each event is handled on its own. If either one raises sysRst, both coreRst bits stay low for the whole window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| wdTimeout | input | 2 | One-cycle timeout pulse from each watchdog |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 scope, 1 run, 2 interrupt clear |
| regWrData | input | 2 | Write data, bit i for watchdog or core i |
| coreStop | input | 2 | Core i is in its stop state |
| coreStandby | input | 2 | Domain of core i is in standby |
| coreRst | output | 2 | Reset to core i |
| sysRst | output | 1 | Full system reset |
| wdRst | output | 2 | Reset back into watchdog i |
| crossIrq | output | 2 | Latched interrupt to core i, raised when the partner watchdog fails |
| wdFreeze | output | 2 | Freeze for watchdog i |
| wdClear | output | 2 | Hold-in-reset for watchdog i |
| wdRun | output | 2 | Sticky run enable for watchdog i |

## Verification
The bench checks that a write of 0 to a set scope bit is ignored. A design that honoured the write would answer the next timeout with a core reset instead of a system reset. It checks that a system reset from one watchdog clears the scope bit of the other one too. A design that cleared only the firing bit would turn the second watchdog's later timeout into a system reset. Simultaneous timeouts with mixed scopes must show a clean system reset with both core resets held low. An interrupt clear that lands together with a fresh timeout must leave the interrupt set, or a failure notice would be lost. Writes of 0 to the run register, followed by timeout and standby clearing, confirm that only the starting edge of the enable matters.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int NUM_WD = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SCOPE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RUN    = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_IRQCLR = 2'd2;

  // strobes handed from control to datapath, one bit per watchdog
  typedef struct packed {
    logic [NUM_WD-1:0] sysFire;
    logic [NUM_WD-1:0] coreFire;
    logic [NUM_WD-1:0] irqClr;
    logic [NUM_WD-1:0] runSet;
  } wdr_strobes_t;
endpackage

// File: rtl/wdr_stretch.sv
module wdr_stretch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (fire) begin
      remain <= CW'(LEN);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);
endmodule

// File: rtl/wdr_ctrl.sv
module wdr_ctrl
  import wdr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_WD-1:0] wdTimeout,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_WD-1:0] regWrData,
  output wdr_strobes_t      strobes,
  output logic [NUM_WD-1:0] scopeBits
);
  logic hitScope;
  logic hitRun;
  logic hitClr;

  always_comb begin
    hitScope = regWrEn && (regAddr == ADDR_SCOPE);
    hitRun   = regWrEn && (regAddr == ADDR_RUN);
    hitClr   = regWrEn && (regAddr == ADDR_IRQCLR);

    strobes.sysFire  = wdTimeout & scopeBits;
    strobes.coreFire = wdTimeout & ~scopeBits;
    strobes.irqClr   = hitClr ? regWrData : '0;
    strobes.runSet   = hitRun ? regWrData : '0;
  end

  // scope bits only ever go up from software; a system reset drops them all
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scopeBits <= '0;
    end else if (|strobes.sysFire) begin
      scopeBits <= '0;
    end else if (hitScope) begin
      scopeBits <= scopeBits | regWrData;
    end
  end
endmodule

// File: rtl/wdr_datapath.sv
module wdr_datapath
  import wdr_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdr_strobes_t      strobes,
  input  logic [NUM_WD-1:0] coreStop,
  input  logic [NUM_WD-1:0] coreStandby,
  output logic [NUM_WD-1:0] coreRst,
  output logic              sysRst,
  output logic [NUM_WD-1:0] wdRst,
  output logic [NUM_WD-1:0] crossIrq,
  output logic [NUM_WD-1:0] wdFreeze,
  output logic [NUM_WD-1:0] wdClear,
  output logic [NUM_WD-1:0] wdRun
);
  logic sysActive;
  logic [NUM_WD-1:0] coreActive;
  logic [NUM_WD-1:0] anyFire;

  assign anyFire = strobes.sysFire | strobes.coreFire;

  wdr_stretch #(.LEN(PULSE_LEN)) u_sysStretch (
    .clk    (clk),
    .rstN   (rstN),
    .fire   (|strobes.sysFire),
    .active (sysActive)
  );

  assign sysRst = sysActive;

  for (genvar i = 0; i < NUM_WD; i++) begin : g_wd
    localparam int PARTNER = NUM_WD - 1 - i;

    wdr_stretch #(.LEN(PULSE_LEN)) u_coreStretch (
      .clk    (clk),
      .rstN   (rstN),
      .fire   (strobes.coreFire[i]),
      .active (coreActive[i])
    );

    wdr_stretch #(.LEN(PULSE_LEN)) u_wdStretch (
      .clk    (clk),
      .rstN   (rstN),
      .fire   (anyFire[i]),
      .active (wdRst[i])
    );

    // a system reset already covers the cores
    assign coreRst[i] = coreActive[i] & ~sysActive;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        crossIrq[i] <= 1'b0;
      end else if (anyFire[PARTNER]) begin
        crossIrq[i] <= 1'b1;
      end else if (strobes.irqClr[i]) begin
        crossIrq[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wdRun[i] <= 1'b0;
      end else if (anyFire[i] || coreStandby[i]) begin
        wdRun[i] <= 1'b0;
      end else if (strobes.runSet[i]) begin
        wdRun[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wdFreeze[i] <= 1'b0;
        wdClear[i]  <= 1'b0;
      end else begin
        wdFreeze[i] <= coreStop[i];
        wdClear[i]  <= coreStandby[i];
      end
    end
  end
endmodule

// File: rtl/wdr_router.sv
module wdr_router
  import wdr_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_WD-1:0] wdTimeout,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_WD-1:0] regWrData,
  input  logic [NUM_WD-1:0] coreStop,
  input  logic [NUM_WD-1:0] coreStandby,
  output logic [NUM_WD-1:0] coreRst,
  output logic              sysRst,
  output logic [NUM_WD-1:0] wdRst,
  output logic [NUM_WD-1:0] crossIrq,
  output logic [NUM_WD-1:0] wdFreeze,
  output logic [NUM_WD-1:0] wdClear,
  output logic [NUM_WD-1:0] wdRun
);
  wdr_strobes_t      strobes;
  logic [NUM_WD-1:0] scopeBits;

  wdr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wdTimeout (wdTimeout),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strobes   (strobes),
    .scopeBits (scopeBits)
  );

  wdr_datapath #(.PULSE_LEN(PULSE_LEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .coreStop    (coreStop),
    .coreStandby (coreStandby),
    .coreRst     (coreRst),
    .sysRst      (sysRst),
    .wdRst       (wdRst),
    .crossIrq    (crossIrq),
    .wdFreeze    (wdFreeze),
    .wdClear     (wdClear),
    .wdRun       (wdRun)
  );
endmodule

// File: rtl/wdr_router_chk.sv
module wdr_router_chk
  import wdr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [NUM_WD-1:0] wdTimeout,
  input logic [NUM_WD-1:0] coreStop,
  input logic [NUM_WD-1:0] coreStandby,
  input logic [NUM_WD-1:0] coreRst,
  input logic              sysRst,
  input logic [NUM_WD-1:0] wdRst,
  input logic [NUM_WD-1:0] crossIrq,
  input logic [NUM_WD-1:0] wdFreeze,
  input logic [NUM_WD-1:0] wdRun,
  input logic [NUM_WD-1:0] scopeBits
);
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R3
  sys_over_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |-> (coreRst == '0));

  // R8
  freeze_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (wdFreeze == $past(coreStop)));

  for (genvar i = 0; i < NUM_WD; i++) begin : g_chk
    localparam int PARTNER = NUM_WD - 1 - i;

    // R6
    wd_rst_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      wdTimeout[i] |=> wdRst[i]);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $rose(crossIrq[i])) |-> $past(wdTimeout[PARTNER]));

    // R4
    scope_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $fell(scopeBits[i])) |-> ($past(wdTimeout & scopeBits) != '0));

    // R10
    run_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pastValid && $fell(wdRun[i])) |-> $past(wdTimeout[i] || coreStandby[i]));
  end
endmodule

bind wdr_router wdr_router_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wdTimeout   (wdTimeout),
  .coreStop    (coreStop),
  .coreStandby (coreStandby),
  .coreRst     (coreRst),
  .sysRst      (sysRst),
  .wdRst       (wdRst),
  .crossIrq    (crossIrq),
  .wdFreeze    (wdFreeze),
  .wdRun       (wdRun),
  .scopeBits   (scopeBits)
);

// File: tb/tb_wdr_router.sv
module tb_wdr_router;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] wdTimeout = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [1:0] regWrData = '0;
  logic [1:0] coreStop = '0;
  logic [1:0] coreStandby = '0;
  logic [1:0] coreRst, wdRst, crossIrq, wdFreeze, wdClear, wdRun;
  logic       sysRst;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdr_router dut (
    .clk(clk), .rstN(rstN), .wdTimeout(wdTimeout), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .coreStop(coreStop),
    .coreStandby(coreStandby), .coreRst(coreRst), .sysRst(sysRst),
    .wdRst(wdRst), .crossIrq(crossIrq), .wdFreeze(wdFreeze),
    .wdClear(wdClear), .wdRun(wdRun)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [1:0] mask);
    wdTimeout = mask;
    step();
    wdTimeout = '0;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [1:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    step();
    regWrEn = 1'b0;
  endtask

  // checks the 4-cycle window that starts at the current negedge
  task automatic window(input string req, input logic [1:0] expCore, input logic expSys, input logic [1:0] expWd);
    for (int k = 0; k < 4; k++) begin
      chk(req, "coreRst in window", 32'(coreRst), 32'(expCore));
      chk(req, "sysRst in window", 32'(sysRst), 32'(expSys));
      chk(req, "wdRst in window", 32'(wdRst), 32'(expWd));
      step();
    end
    chk(req, "coreRst after window", 32'(coreRst), 0);
    chk(req, "sysRst after window", 32'(sysRst), 0);
    chk(req, "wdRst after window", 32'(wdRst), 0);
  endtask

  task automatic t_reset();
    chk("R1", "coreRst", 32'(coreRst), 0);
    chk("R1", "sysRst", 32'(sysRst), 0);
    chk("R1", "wdRst", 32'(wdRst), 0);
    chk("R1", "crossIrq", 32'(crossIrq), 0);
    chk("R1", "wdFreeze", 32'(wdFreeze), 0);
    chk("R1", "wdClear", 32'(wdClear), 0);
    chk("R1", "wdRun", 32'(wdRun), 0);
  endtask

  task automatic t_coreScope();
    pulse(2'b01);
    window("R2", 2'b01, 1'b0, 2'b01);
    chk("R7", "irq to core1", 32'(crossIrq), 32'b10);
    pulse(2'b10);
    window("R2", 2'b10, 1'b0, 2'b10);
    chk("R7", "irq both", 32'(crossIrq), 32'b11);
  endtask

  task automatic t_irqClear();
    wr(2'd2, 2'b10);
    chk("R7", "clear core1 irq", 32'(crossIrq), 32'b01);
    // clear of bit0 and a new wd1 timeout together: set wins
    wdTimeout = 2'b10; regWrEn = 1'b1; regAddr = 2'd2; regWrData = 2'b01;
    step();
    wdTimeout = '0; regWrEn = 1'b0;
    chk("R7", "set beats clear", 32'(crossIrq), 32'b01);
    repeat (5) step();
    wr(2'd2, 2'b11);
    chk("R7", "all cleared", 32'(crossIrq), 0);
  endtask

  task automatic t_scope();
    wr(2'd0, 2'b11);
    wr(2'd0, 2'b00);
    pulse(2'b01);
    window("R3", 2'b00, 1'b1, 2'b01);
    // R4 zero write ignored (seen as sysRst above); R5 scopes now cleared
    pulse(2'b10);
    window("R5", 2'b10, 1'b0, 2'b10);
    pulse(2'b01);
    window("R5", 2'b01, 1'b0, 2'b01);
    wr(2'd2, 2'b11);
  endtask

  task automatic t_both();
    pulse(2'b11);
    window("R11", 2'b11, 1'b0, 2'b11);
    chk("R11", "irq both", 32'(crossIrq), 32'b11);
    wr(2'd0, 2'b10);
    pulse(2'b11);
    window("R11", 2'b00, 1'b1, 2'b11);
    pulse(2'b10);
    window("R5", 2'b10, 1'b0, 2'b10);
    wr(2'd2, 2'b11);
  endtask

  task automatic t_power();
    coreStop = 2'b01;
    step();
    chk("R8", "freeze core0", 32'(wdFreeze), 32'b01);
    coreStop = 2'b10;
    step();
    chk("R8", "freeze core1", 32'(wdFreeze), 32'b10);
    coreStop = '0;
    step();
    chk("R8", "freeze off", 32'(wdFreeze), 0);
  endtask

  task automatic t_run();
    wr(2'd1, 2'b11);
    chk("R10", "run set", 32'(wdRun), 32'b11);
    wr(2'd1, 2'b00);
    chk("R10", "zero write ignored", 32'(wdRun), 32'b11);
    pulse(2'b10);
    chk("R10", "timeout drops run", 32'(wdRun), 32'b01);
    repeat (4) step();
    coreStandby = 2'b01;
    step();
    chk("R9", "wdClear", 32'(wdClear), 32'b01);
    chk("R9", "standby drops run", 32'(wdRun), 0);
    coreStandby = '0;
    step();
    chk("R9", "wdClear off", 32'(wdClear), 0);
    wr(2'd2, 2'b11);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_coreScope();
    t_irqClear();
    t_scope();
    t_both();
    t_power();
    t_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule